// File: doc/BRIEF.md
# Branch Redirect and Squash Controller for an Eight-Stage Pipeline

This block is the control logic that handles branches in an in-order integer pipeline with eight stages: IF, IS, RF, EX, DF, DS, TC and WB. Fetch takes two stages, IF and IS. Decode and register read take place in RF. A jump target is available at the end of RF. The outcome of a conditional branch, and its computed target, are available only in EX. Because of this, every branch leaves some fetch slots without useful work.

A two-bit mode input selects one of three static policies:

- **Hold.** Fetch waits until the branch resolves.
- **Guess taken.** Fetch follows the target computed in decode.
- **Guess not taken.** Fetch keeps going down the sequential path.

Each cycle the block chooses where the next fetch address comes from, and it may withhold the fetch in the current slot. It also raises per-stage kill bits that turn wrong-path instructions in IF, IS and RF into bubbles.

The block keeps its own record of which stages hold live instructions. A branch that has already been squashed therefore has no effect. This record also shows that a killed instruction never reaches DF, where memory is written, or WB, where registers are written. A free-running counter adds up every lost slot, so the cost of each policy can be measured directly.

Top module: `brflush_ctl`

## Requirements
- R1: While reset (synchronous, active high) is asserted, kill is 0, stall is 0, pc_sel is 0, penalty_cnt is 0, and mem_valid and commit_valid are 0.
- R2: An unconditional branch that is live in RF raises kill bits 0 (IF) and 1 (IS) in that same cycle, sets pc_sel to 1 and drives next_pc with dec_target. This holds in every mode, and the total penalty is 2.
- R3: In mode 0 (hold), a live conditional branch in RF kills IF and IS with pc_sel 0. In the next cycle, when the branch is in EX, stall is 1, kill is 3'b111 and pc_sel is 2 with next_pc equal to ex_target if the branch is taken. If it is not taken, pc_sel is 3 with next_pc equal to the branch's rf_fallthru. The penalty is 3 in both cases. Mode 3 behaves like mode 0.
- R4: In mode 1 (guess taken), a live conditional branch in RF kills IF and IS and sets pc_sel to 1. In EX, a taken branch causes no further action, for a penalty of 2. A branch that is not taken gives kill 3'b111 and pc_sel 3 (fall-through), for a penalty of 3.
- R5: In mode 2 (guess not taken), a conditional branch in RF causes no kill and keeps pc_sel at 0. A branch that is not taken costs 0. A taken branch, once in EX, gives kill 3'b111 and pc_sel 2 with next_pc equal to ex_target, for a penalty of 3.
- R6: When a redirect from EX and a live branch in RF fall in the same cycle, the EX redirect wins. The RF branch is killed, it does not select its target and it adds nothing to the penalty.
- R7: A branch signalled by decode while the RF stage holds a squashed instruction does not redirect, does not kill and does not count.
- R8: Instructions killed in IF, IS or RF never appear as valid on mem_valid (DF) or commit_valid (WB).
- R9: penalty_cnt increases by one for each live instruction that is killed and for each cycle in which stall is asserted.
- R10: Encodings: pc_sel 0 takes seq_pc, 1 takes dec_target, 2 takes ex_target and 3 takes the fall-through address. Kill bit 0 is IF, bit 1 is IS and bit 2 is RF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Policy: 0 hold, 1 guess taken, 2 guess not taken, 3 as hold |
| dec_br | input | 1 | The instruction in RF is a branch |
| dec_uncond | input | 1 | The branch in RF is unconditional |
| dec_target | input | AW | Target computed in decode |
| rf_fallthru | input | AW | Address after the branch in RF |
| ex_taken | input | 1 | Outcome of the conditional branch in EX |
| ex_target | input | AW | Target resolved in EX |
| seq_pc | input | AW | Sequential next fetch address |
| pc_sel | output | 2 | Source of the next fetch address |
| next_pc | output | AW | Selected next fetch address |
| stall | output | 1 | The fetch slot of this cycle is empty |
| kill | output | 3 | Squash bits for IF, IS and RF |
| mem_valid | output | 1 | DF holds a live instruction |
| commit_valid | output | 1 | WB holds a live instruction |
| penalty_cnt | output | CW | Count of lost slots |

## Verification
A taken conditional branch can resolve in EX in the same cycle that decode presents a second branch in RF. In that cycle, both the squash of the younger instruction and its own redirect compete for the fetch-address select. The bench provokes this in guess-not-taken mode by issuing a conditional branch followed directly by a jump. It expects kill 3'b111, selection of the EX target, and a total penalty of exactly 3 rather than 5. A second test raises a branch flag on slots already squashed, and expects no reaction at all.

// File: rtl/brf_pkg.sv
package brf_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD     = 2'd0,
    MODE_GUESS_T  = 2'd1,
    MODE_GUESS_NT = 2'd2,
    MODE_RSVD     = 2'd3
  } scheme_e;

  typedef enum logic [1:0] {
    SEL_SEQ  = 2'd0,
    SEL_DEC  = 2'd1,
    SEL_EXE  = 2'd2,
    SEL_FALL = 2'd3
  } pcsel_e;

  localparam int KILL_W = 3;
  localparam int N_STAGES = 8;
endpackage

// File: rtl/brf_track.sv
module brf_track #(
  parameter int AW = 32,
  parameter int STAGES = brf_pkg::N_STAGES
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      if_live,
  input  logic [brf_pkg::KILL_W-1:0] kill,
  input  logic                      rf_cond_acc,
  input  logic [AW-1:0]             rf_ft,
  output logic                      v_is,
  output logic                      v_rf,
  output logic                      v_ex,
  output logic                      ex_cond,
  output logic [AW-1:0]             ex_ft,
  output logic                      v_df,
  output logic                      v_wb
);
  localparam int DF_IDX = 4;

  logic [STAGES-1:1] vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld     <= '0;
      ex_cond <= 1'b0;
      ex_ft   <= '0;
    end else begin
      vld[1] <= if_live & ~kill[0];
      vld[2] <= vld[1] & ~kill[1];
      vld[3] <= vld[2] & ~kill[2];
      vld[STAGES-1:DF_IDX] <= vld[STAGES-2:DF_IDX-1];
      ex_cond <= rf_cond_acc;
      if (rf_cond_acc) ex_ft <= rf_ft;
    end
  end

  assign v_is = vld[1];
  assign v_rf = vld[2];
  assign v_ex = vld[3];
  assign v_df = vld[DF_IDX];
  assign v_wb = vld[STAGES-1];
endmodule

// File: rtl/brf_decide.sv
module brf_decide
  import brf_pkg::*;
(
  input  scheme_e             mode,
  input  logic                v_rf,
  input  logic                dec_br,
  input  logic                dec_uncond,
  input  logic                v_ex,
  input  logic                ex_cond,
  input  logic                ex_taken,
  output logic [KILL_W-1:0]   kill,
  output pcsel_e              sel,
  output logic                rf_cond_acc,
  output logic                stall_d
);
  logic hold_m, rf_br, ex_br, ex_redir;

  always_comb begin
    hold_m   = (mode == MODE_HOLD) || (mode == MODE_RSVD);
    rf_br    = v_rf & dec_br;
    ex_br    = v_ex & ex_cond;
    ex_redir = ex_br & (hold_m |
                        ((mode == MODE_GUESS_T) & ~ex_taken) |
                        ((mode == MODE_GUESS_NT) & ex_taken));
    kill = '0;
    sel  = SEL_SEQ;
    if (ex_redir) begin
      kill = '1;
      if (hold_m) sel = ex_taken ? SEL_EXE : SEL_FALL;
      else if (mode == MODE_GUESS_T) sel = SEL_FALL;
      else sel = SEL_EXE;
    end else if (rf_br) begin
      if (dec_uncond || mode == MODE_GUESS_T) begin
        kill = 3'b011;
        sel  = SEL_DEC;
      end else if (hold_m) begin
        kill = 3'b011;
      end
    end
    rf_cond_acc = rf_br & ~dec_uncond & ~ex_redir;
    stall_d     = rf_cond_acc & hold_m;
  end
endmodule

// File: rtl/brf_count.sv
module brf_count #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + CW'(inc);
  end
endmodule

// File: rtl/brflush_ctl.sv
module brflush_ctl #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic          dec_br,
  input  logic          dec_uncond,
  input  logic [AW-1:0] dec_target,
  input  logic [AW-1:0] rf_fallthru,
  input  logic          ex_taken,
  input  logic [AW-1:0] ex_target,
  input  logic [AW-1:0] seq_pc,
  output logic [1:0]    pc_sel,
  output logic [AW-1:0] next_pc,
  output logic          stall,
  output logic [2:0]    kill,
  output logic          mem_valid,
  output logic          commit_valid,
  output logic [CW-1:0] penalty_cnt
);
  import brf_pkg::*;

  logic          stall_q, stall_d, rf_cond_acc;
  logic          v_is, v_rf, v_ex, ex_cond;
  logic [AW-1:0] ex_ft;
  pcsel_e        sel;
  logic [2:0]    inc;

  brf_decide u_dec (
    .mode(scheme_e'(mode)), .v_rf(v_rf), .dec_br(dec_br),
    .dec_uncond(dec_uncond), .v_ex(v_ex), .ex_cond(ex_cond),
    .ex_taken(ex_taken), .kill(kill), .sel(sel),
    .rf_cond_acc(rf_cond_acc), .stall_d(stall_d)
  );

  brf_track #(.AW(AW), .STAGES(N_STAGES)) u_trk (
    .clk(clk), .rst(rst), .if_live(~stall_q), .kill(kill),
    .rf_cond_acc(rf_cond_acc), .rf_ft(rf_fallthru),
    .v_is(v_is), .v_rf(v_rf), .v_ex(v_ex), .ex_cond(ex_cond),
    .ex_ft(ex_ft), .v_df(mem_valid), .v_wb(commit_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) stall_q <= 1'b0;
    else     stall_q <= stall_d;
  end

  always_comb begin
    inc = {2'b00, stall_q}
        + {2'b00, kill[0] & ~stall_q}
        + {2'b00, kill[1] & v_is}
        + {2'b00, kill[2] & v_rf};
    unique case (sel)
      SEL_DEC:  next_pc = dec_target;
      SEL_EXE:  next_pc = ex_target;
      SEL_FALL: next_pc = ex_ft;
      default:  next_pc = seq_pc;
    endcase
  end

  brf_count #(.CW(CW)) u_cnt (.clk(clk), .rst(rst), .inc(inc), .cnt(penalty_cnt));

  assign pc_sel = sel;
  assign stall  = stall_q;
endmodule

// File: rtl/brflush_ctl_chk.sv
module brflush_ctl_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    mode,
  input logic [1:0]    pc_sel,
  input logic [2:0]    kill,
  input logic          stall,
  input logic          v_rf,
  input logic [CW-1:0] penalty_cnt
);
  p_dec_sel_kills_r2: assert property (@(posedge clk) disable iff (rst)
    pc_sel == 2'd1 |-> kill[1:0] == 2'b11);

  p_stall_redirects_r3: assert property (@(posedge clk) disable iff (rst)
    stall |-> (pc_sel == 2'd2 || pc_sel == 2'd3) && kill == 3'b111);

  p_nt_no_fall_r5: assert property (@(posedge clk) disable iff (rst)
    mode == 2'd2 |-> pc_sel != 2'd3);

  p_kill_nested_r6: assert property (@(posedge clk) disable iff (rst)
    kill[2] |-> kill[1:0] == 2'b11);

  p_dead_rf_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !v_rf |-> pc_sel != 2'd1);

  p_cnt_step_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (penalty_cnt - $past(penalty_cnt)) <= CW'(4));
endmodule

bind brflush_ctl brflush_ctl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .pc_sel(pc_sel), .kill(kill),
  .stall(stall), .v_rf(v_rf), .penalty_cnt(penalty_cnt)
);

// File: tb/sim_brflush_ctl.sv
`timescale 1ns/1ps
module sim_brflush_ctl;
  localparam int AW = 32;
  localparam int CW = 32;
  localparam logic [AW-1:0] T_DEC = 32'h0000_1000;
  localparam logic [AW-1:0] T_EXE = 32'h0000_2000;
  localparam logic [AW-1:0] T_FT  = 32'h0000_0104;
  localparam logic [AW-1:0] T_SEQ = 32'h0000_0200;

  logic clk = 0, rst = 1;
  logic [1:0] mode = 0;
  logic dec_br = 0, dec_uncond = 0, ex_taken = 0;
  logic [AW-1:0] pc_sel_dummy;
  logic [1:0] pc_sel;
  logic [AW-1:0] next_pc;
  logic stall, mem_valid, commit_valid;
  logic [2:0] kill;
  logic [CW-1:0] penalty_cnt;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  brflush_ctl #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .dec_br(dec_br), .dec_uncond(dec_uncond),
    .dec_target(T_DEC), .rf_fallthru(T_FT), .ex_taken(ex_taken),
    .ex_target(T_EXE), .seq_pc(T_SEQ), .pc_sel(pc_sel), .next_pc(next_pc),
    .stall(stall), .kill(kill), .mem_valid(mem_valid),
    .commit_valid(commit_valid), .penalty_cnt(penalty_cnt)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dec_br = 0; dec_uncond = 0; ex_taken = 0;
    end
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 kill", kill, 0);
    chk("R1 stall", stall, 0);
    chk("R1 pc_sel", pc_sel, 0);
    chk("R1 count", penalty_cnt, 0);
    chk("R1 mem_valid", mem_valid, 0);
    chk("R1 commit_valid", commit_valid, 0);
    rst = 0;
  endtask

  // R2 and R8: jump in every mode, bubbles tracked down to DF and WB
  task automatic t_uncond(input logic [1:0] m);
    logic [CW-1:0] base;
    mode = m;
    idle(10);
    base = penalty_cnt;
    @(negedge clk);
    dec_br = 1; dec_uncond = 1; #1;
    chk("R2 kill", kill, 3'b011);
    chk("R2 pc_sel R10", pc_sel, 1);
    chk("R2 next_pc", next_pc, T_DEC);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      dec_br = 0; dec_uncond = 0; #1;
      if (k == 2) chk("R8 branch at DF", mem_valid, 1);
      if (k == 3 || k == 4) chk("R8 killed not at DF", mem_valid, 0);
      if (k == 5) chk("R8 target at DF", mem_valid, 1);
      if (k == 6 || k == 7) chk("R8 killed not at WB", commit_valid, 0);
      if (k == 8) chk("R8 target at WB", commit_valid, 1);
    end
    chk("R2 R9 penalty", penalty_cnt - base, 2);
  endtask

  task automatic t_hold_cond(input logic [1:0] m, input logic tk);
    logic [CW-1:0] base;
    mode = m;
    idle(10);
    base = penalty_cnt;
    @(negedge clk);
    dec_br = 1; dec_uncond = 0; #1;
    chk("R3 rf kill", kill, 3'b011);
    chk("R3 rf pc_sel", pc_sel, 0);
    @(negedge clk);
    dec_br = 0; ex_taken = tk; #1;
    chk("R3 stall", stall, 1);
    chk("R3 ex kill", kill, 3'b111);
    chk("R3 ex pc_sel", pc_sel, tk ? 2 : 3);
    chk("R3 next_pc", next_pc, tk ? T_EXE : T_FT);
    idle(4);
    chk("R3 stall released", stall, 0);
    chk("R3 R9 penalty", penalty_cnt - base, 3);
  endtask

  task automatic t_guess_taken(input logic tk);
    logic [CW-1:0] base;
    mode = 1;
    idle(10);
    base = penalty_cnt;
    @(negedge clk);
    dec_br = 1; dec_uncond = 0; #1;
    chk("R4 rf kill", kill, 3'b011);
    chk("R4 rf pc_sel", pc_sel, 1);
    @(negedge clk);
    dec_br = 0; ex_taken = tk; #1;
    chk("R4 ex kill", kill, tk ? 3'b000 : 3'b111);
    chk("R4 ex pc_sel", pc_sel, tk ? 0 : 3);
    if (!tk) chk("R4 fall-through", next_pc, T_FT);
    idle(4);
    chk("R4 R9 penalty", penalty_cnt - base, tk ? 2 : 3);
  endtask

  task automatic t_guess_not(input logic tk);
    logic [CW-1:0] base;
    mode = 2;
    idle(10);
    base = penalty_cnt;
    @(negedge clk);
    dec_br = 1; dec_uncond = 0; #1;
    chk("R5 rf kill", kill, 0);
    chk("R5 rf pc_sel", pc_sel, 0);
    @(negedge clk);
    dec_br = 0; ex_taken = tk; #1;
    chk("R5 ex kill", kill, tk ? 3'b111 : 3'b000);
    chk("R5 ex pc_sel", pc_sel, tk ? 2 : 0);
    if (tk) chk("R5 ex target", next_pc, T_EXE);
    idle(4);
    chk("R5 R9 penalty", penalty_cnt - base, tk ? 3 : 0);
  endtask

  // R6: taken branch in EX meets jump in RF
  task automatic t_priority();
    logic [CW-1:0] base;
    mode = 2;
    idle(10);
    base = penalty_cnt;
    @(negedge clk);
    dec_br = 1; dec_uncond = 0; #1;
    @(negedge clk);
    dec_br = 1; dec_uncond = 1; ex_taken = 1; #1;
    chk("R6 kill", kill, 3'b111);
    chk("R6 pc_sel", pc_sel, 2);
    chk("R6 next_pc", next_pc, T_EXE);
    @(negedge clk);
    dec_br = 0; dec_uncond = 0; ex_taken = 0; #1;
    chk("R6 no late action", kill, 0);
    idle(4);
    chk("R6 penalty", penalty_cnt - base, 3);
  endtask

  // R7: branch flags on squashed RF slots are ignored
  task automatic t_squashed();
    logic [CW-1:0] base;
    mode = 1;
    idle(10);
    base = penalty_cnt;
    @(negedge clk);
    dec_br = 1; dec_uncond = 1; #1;
    chk("R7 first jump kill", kill, 3'b011);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      dec_br = 1; dec_uncond = 1; #1;
      chk("R7 dead kill", kill, 0);
      chk("R7 dead pc_sel", pc_sel, 0);
    end
    idle(4);
    chk("R7 penalty", penalty_cnt - base, 2);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    t_reset();
    for (int m = 0; m < 3; m++) t_uncond(2'(m));
    t_hold_cond(0, 1);
    t_hold_cond(0, 0);
    t_hold_cond(3, 1);
    t_guess_taken(1);
    t_guess_taken(0);
    t_guess_not(0);
    t_guess_not(1);
    t_priority();
    t_squashed();
    idle(2);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog all requirements: actual hung expected completion");
      summary();
      $finish;
    end
  end
endmodule